// File: doc/BRIEF.md
# SPI Register-Access Peripheral

This block is the peripheral end of a fixed-format serial link into a small banked register file. Typical uses are an I/O expander or a configuration slave. The serial clock, the active-low select and the controller-to-peripheral data line are sampled by a faster system clock and edge-detected, so every register update happens in the system clock domain. Each select-low period carries one 24-bit command frame. The frame is decoded into a direction flag, a 7-bit register address, an 8-bit port mask and an 8-bit data byte.

The register file holds `NUM_KINDS` register kinds. Each kind is banked across `NUM_PORTS` ports of 8 bits. The 7-bit address is read as `{kind, port}`, with the port index in the low `$clog2(NUM_PORTS)` bits. A write stores the data byte into the addressed kind on every port whose mask bit is set, and ignores the port bits of the address. A read returns the addressed register in the last eight bit slots of the same frame. The peripheral-to-controller line comes out as a data bit plus an output enable, and the pad driver sits outside the block.

Top module: `spi_rp_top`

## Requirements
- R1: After reset every register reads as 0x00 and `poci_oe` is low.
- R2: Frames use SPI mode 0: the clock idles low, `pico` is sampled on rising `sclk` edges most-significant bit first, and `poci` changes only after falling `sclk` edges.
- R3: A frame with bit 23 = 0 is a write. Bits [22:16] form the address `{kind, port}`, with the port in the low 2 bits, which a write ignores. Bits [15:8] form the port mask and bits [7:0] the data.
- R4: A write stores the data byte into register `kind` of port n for every n below `NUM_PORTS` whose mask bit 8+n is set. Several set bits write all of the selected ports.
- R5: A frame with bit 23 = 1 is a read. Its lower 16 incoming bits are ignored and write nothing. `poci` carries 0 for the first 16 bit slots, then the addressed register MSB first in the last 8 slots. A write frame returns 0 in all 24 slots.
- R6: If `cs_n` rises before the 24th rising `sclk` edge, the frame is discarded and no register changes.
- R7: `poci_oe` is high only while the synchronised `cs_n` is low, and falls within two system clocks after `cs_n` rises.
- R8: A write to a kind at or above `NUM_KINDS`, or mask bits at or above `NUM_PORTS`, change nothing. A read of such a kind, or of a port index at or above `NUM_PORTS`, returns 0x00.
- R9: Rising `sclk` edges after the 24th within one select period are ignored, and at most one write is committed per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low frame select |
| pico | input | 1 | Serial data from controller |
| poci | output | 1 | Serial data to controller, valid while `poci_oe` is high |
| poci_oe | output | 1 | Output enable for the `poci` pad driver |

## Verification
The assertions assume that `sclk`, `cs_n` and `pico` are stable for several system clocks around every edge, so that the two-flop synchronisers see each transition once. They also assume `cs_n` is held high while reset is applied. The stimulus keeps each `sclk` phase five system clocks long and changes `pico` only in the low phase. It also holds `cs_n` high for several clocks between frames, and idle with select high across reset.

// File: rtl/spi_rp_pkg.sv
// Shared constants and types for the SPI register-access peripheral.
// Assumes the fixed 24-bit frame: 1 direction bit, 7 address bits, 8 mask bits, 8 data bits.
package spi_rp_pkg;
    localparam int FRAME_W = 24;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int MASK_W  = 8;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    // bit-count values at which the frame logic acts
    localparam logic [CNT_W-1:0] CNT_ADDR_DONE = CNT_W'(ADDR_W);            // 8th bit arriving
    localparam logic [CNT_W-1:0] CNT_LAST      = CNT_W'(FRAME_W - 1);       // 24th bit arriving
    localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_DATA_OUT  = CNT_W'(FRAME_W - DATA_W);  // read data slots begin

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [MASK_W-1:0] mask;
        logic [DATA_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/spi_rp_sync.sv
// Brings the serial clock, select and data pins into the system clock domain.
// Assumes each pin is stable for more than SYNC_STAGES+1 system clocks per phase.
module spi_rp_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic pico,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic pico_s
);
    logic [SYNC_STAGES-1:0] sclk_pipe;
    logic [SYNC_STAGES-1:0] cs_pipe;
    logic [SYNC_STAGES-1:0] pico_pipe;
    logic                   sclk_prev;

    // synchroniser chains; select resets to inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            cs_pipe   <= '1;
            pico_pipe <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk};
            cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
            pico_pipe <= {pico_pipe[SYNC_STAGES-2:0], pico};
            sclk_prev <= sclk_pipe[SYNC_STAGES-1];
        end
    end

    // single-cycle edge strobes and synchronised levels
    always_comb begin
        sclk_rise = sclk_pipe[SYNC_STAGES-1] & ~sclk_prev;
        sclk_fall = ~sclk_pipe[SYNC_STAGES-1] & sclk_prev;
        cs_act    = ~cs_pipe[SYNC_STAGES-1];
        pico_s    = pico_pipe[SYNC_STAGES-1];
    end
endmodule

// File: rtl/spi_rp_frame.sv
// Frame engine: counts bits, assembles the 24-bit command, commits a write after
// the 24th bit, and snapshots and serialises read data. Assumes single-cycle edge strobes.
module spi_rp_frame
    import spi_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              pico_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output wr_req_t           wr_req,
    output logic              poci_q,
    output logic [CNT_W-1:0]  bit_cnt
);
    logic [FRAME_W-2:0] shift_q;
    logic [FRAME_W-1:0] shift_nx;
    logic [DATA_W-1:0]  rd_buf;
    logic               bit_take;

    // next frame contents once the current input bit is included
    always_comb begin
        shift_nx = {shift_q, pico_s};
        rd_addr  = shift_nx[ADDR_W-1:0];
        bit_take = cs_act && sclk_rise && (bit_cnt < CNT_FULL);
    end

    // bit counter and input shift register, cleared while deselected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shift_q <= '0;
        end else if (!cs_act) begin
            bit_cnt <= '0;
        end else if (bit_take) begin
            bit_cnt <= bit_cnt + 1'b1;
            shift_q <= shift_nx[FRAME_W-2:0];
        end
    end

    // write commit on the 24th bit of a write frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en  <= 1'b0;
            wr_req <= '0;
        end else begin
            wr_en <= 1'b0;
            if (bit_take && bit_cnt == CNT_LAST && !shift_nx[FRAME_W-1]) begin
                wr_en  <= 1'b1;
                wr_req <= shift_nx[FRAME_W-2:0];
            end
        end
    end

    // read snapshot after the address and serialisation on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_buf <= '0;
            poci_q <= 1'b0;
        end else if (!cs_act) begin
            poci_q <= 1'b0;
        end else begin
            if (bit_take && bit_cnt == CNT_ADDR_DONE)
                rd_buf <= shift_nx[ADDR_W] ? rd_data : '0;
            if (sclk_fall && bit_cnt >= CNT_DATA_OUT && bit_cnt < CNT_FULL) begin
                poci_q <= rd_buf[DATA_W-1];
                rd_buf <= {rd_buf[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_rp_regfile.sv
// Banked register file: NUM_KINDS kinds times NUM_PORTS ports of bytes.
// Write uses a port mask; read is combinational and returns 0 out of range. Needs 2..8 ports.
module spi_rp_regfile
    import spi_rp_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int NUM_KINDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PSEL_W = $clog2(NUM_PORTS);
    localparam int KIND_W = ADDR_W - PSEL_W;

    logic [DATA_W-1:0] regs [NUM_KINDS][NUM_PORTS];
    logic [KIND_W-1:0] wr_kind;
    logic [KIND_W-1:0] rd_kind;
    logic [PSEL_W-1:0] rd_port;
    logic              unused_wr_port;

    assign wr_kind        = wr_req.addr[ADDR_W-1:PSEL_W];
    assign rd_kind        = rd_addr[ADDR_W-1:PSEL_W];
    assign rd_port        = rd_addr[PSEL_W-1:0];
    assign unused_wr_port = ^wr_req.addr[PSEL_W-1:0];

    generate
        if (NUM_PORTS < MASK_W) begin : g_mask_hi
            logic unused_mask_hi;
            assign unused_mask_hi = ^wr_req.mask[MASK_W-1:NUM_PORTS];
        end
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
                // one byte register, written when its kind matches and its mask bit is set
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs[k][p] <= '0;
                    else if (wr_en && wr_req.mask[p] && wr_kind == KIND_W'(k))
                        regs[k][p] <= wr_req.data;
                end
            end
        end
    endgenerate

    // read mux, zero for any kind or port outside the file
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_KINDS; k++)
            for (int p = 0; p < NUM_PORTS; p++)
                if (rd_kind == KIND_W'(k) && rd_port == PSEL_W'(p))
                    rd_data = regs[k][p];
    end
endmodule

// File: rtl/spi_rp_top.sv
// SPI register-access peripheral, mode 0, 24-bit frames into a banked register file.
// Assumes clk is fast enough to see every sclk phase for at least four cycles.
module spi_rp_top
    import spi_rp_pkg::*;
#(
    parameter int NUM_PORTS   = 3,
    parameter int NUM_KINDS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic pico,
    output logic poci,
    output logic poci_oe
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_act;
    logic              pico_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    wr_req_t           wr_req;
    logic              poci_q;
    logic [CNT_W-1:0]  bit_cnt;

    spi_rp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .pico(pico),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .pico_s(pico_s)
    );

    spi_rp_frame u_frame (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_act(cs_act), .pico_s(pico_s), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_req(wr_req), .poci_q(poci_q), .bit_cnt(bit_cnt)
    );

    spi_rp_regfile #(.NUM_PORTS(NUM_PORTS), .NUM_KINDS(NUM_KINDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_req(wr_req),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // pad-side outputs, driven only while the frame is selected
    always_comb begin
        poci_oe = cs_act;
        poci    = cs_act & poci_q;
    end
endmodule

// File: rtl/spi_rp_chk.sv
// Protocol checker for spi_rp_top, attached by bind. Assumes cs_n is high during reset.
module spi_rp_chk
    import spi_rp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             poci,
    input logic             poci_oe,
    input logic             wr_en,
    input logic [CNT_W-1:0] bit_cnt
);
    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(cs_n, 2)) |-> !poci_oe);

    // R7
    oe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(cs_n, 2)) |-> poci_oe);

    // R5
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poci_oe && bit_cnt < CNT_DATA_OUT) |-> !poci);

    // R9
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6
    full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bit_cnt == CNT_FULL && poci_oe));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt != $past(bit_cnt)) |-> (bit_cnt == '0 || bit_cnt == $past(bit_cnt) + 1'b1));
endmodule

bind spi_rp_top spi_rp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .poci(poci), .poci_oe(poci_oe),
    .wr_en(wr_en), .bit_cnt(bit_cnt)
);

// File: tb/tb_spi_rp_top.sv
`timescale 1ns/1ps
module tb_spi_rp_top;
    localparam int NP = 3;
    localparam int NK = 4;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic pico = 1'b0;
    logic poci, poci_oe;

    int checks = 0;
    int errors = 0;
    int mdl [32][4];
    logic mon_en = 1'b0;
    logic cs_prev = 1'b1;
    int   cs_run = 0;

    always #2 clk = ~clk;

    spi_rp_top #(.NUM_PORTS(NP), .NUM_KINDS(NK)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .pico(pico),
        .poci(poci), .poci_oe(poci_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R7 reference: output enable follows select once select has been steady
    always @(negedge clk) begin
        if (cs_n == cs_prev) cs_run++; else cs_run = 0;
        cs_prev = cs_n;
        if (mon_en && cs_run >= 3)
            chk(poci_oe == !cs_n, "R7 oe", int'(poci_oe), int'(!cs_n));
    end

    function automatic int model_rd(input int kind, input int port);
        return (kind < NK && port < NP) ? mdl[kind][port] : 0;
    endfunction

    // one frame of nbits; compares POCI for full frames and updates the model
    task automatic frame(input logic [23:0] tx, input int nbits, input string req);
        logic [23:0] rx = '0;
        int kind = int'(tx[22:18]);
        int port = int'(tx[17:16]);
        logic [23:0] exp = tx[23] ? {16'h0, 8'(model_rd(kind, port))} : 24'h0;
        @(negedge clk) cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            pico = (i < 24) ? tx[23-i] : ~pico;
            repeat (HALF) @(negedge clk);
            if (i < 24) rx[23-i] = poci;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        if (nbits >= 24) begin
            chk(rx == exp, req, int'(rx), int'(exp));
            if (!tx[23] && kind < NK)
                for (int p = 0; p < NP; p++)
                    if (tx[8+p]) mdl[kind][p] = int'(tx[7:0]);
        end
    endtask

    function automatic logic [23:0] wf(input int kind, input int port, input logic [7:0] m, input logic [7:0] d);
        return {1'b0, 5'(kind), 2'(port), m, d};
    endfunction

    function automatic logic [23:0] rf(input int kind, input int port, input logic [15:0] dummy);
        return {1'b1, 5'(kind), 2'(port), dummy};
    endfunction

    task automatic read_all(input string req);
        for (int k = 0; k < NK; k++)
            for (int p = 0; p < NP; p++)
                frame(rf(k, p, 16'h0), 24, req);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 32; k++) for (int p = 0; p < 4; p++) mdl[k][p] = 0;
        repeat (5) @(negedge clk);
        chk(poci_oe == 1'b0, "R1 oe in reset", int'(poci_oe), 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (5) @(negedge clk);
        read_all("R1 reset value");
        // R3 R2 single port write, read back
        frame(wf(0, 0, 8'h01, 8'hA5), 24, "R3 write frame");
        frame(rf(0, 0, 16'h0), 24, "R3 readback");
        frame(rf(0, 1, 16'h0), 24, "R3 other port untouched");
        // R4 multi-port write
        frame(wf(1, 0, 8'h07, 8'h3C), 24, "R4 mask write");
        read_all("R4 readback");
        // R3 port bits of address ignored on write
        frame(wf(2, 3, 8'h04, 8'h81), 24, "R3 addr port ignored");
        read_all("R3 readback");
        // R5 read with busy dummy bits writes nothing
        frame(rf(1, 2, 16'h03FF), 24, "R5 read dummy");
        read_all("R5 no write");
        // R6 aborted frames
        frame(wf(0, 0, 8'h07, 8'h55), 23, "R6 abort 23");
        frame(wf(3, 0, 8'h07, 8'h66), 10, "R6 abort 10");
        read_all("R6 unchanged");
        // R9 extra clocks after 24 bits
        frame(wf(3, 0, 8'h02, 8'hC3), 27, "R9 long frame");
        read_all("R9 single commit");
        // R8 out-of-range kind, port and mask bits
        frame(wf(5, 0, 8'hFF, 8'h99), 24, "R8 bad kind write");
        frame(rf(5, 0, 16'h0), 24, "R8 bad kind read");
        frame(rf(1, 3, 16'h0), 24, "R8 bad port read");
        frame(wf(2, 0, 8'hF8, 8'h11), 24, "R8 high mask bits");
        read_all("R8 unchanged");
        // R2 alternating data patterns
        frame(wf(3, 0, 8'h05, 8'h5A), 24, "R2 pattern");
        frame(wf(0, 0, 8'h02, 8'hFF), 24, "R2 pattern");
        read_all("R2 readback");
        mon_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule